// File: doc/BRIEF.md
# Reset Cause Recorder

This block keeps an always-on register of sticky flags that tell software why the processor went through its last reset. A power-on event sets a single dedicated flag and wipes everything else. The power manager reports a reset category, and the block records the causes that category allows while the processor is held in reset. The causes are a low-power exit, a debug-module system reset request, a software request, and one request bit per hardware peripheral requester.

Right after power-on, all recording other than the power-on flag is muted. It stays muted until the processor reset is first seen released. Several permitted causes can be captured in the same cycle, and flags keep adding up until software clears them. Software reads the flags through a simple read/write port and clears them by writing 1 to a bit.

The register layout is fixed. Bit 0 is power-on, bit 1 is low-power exit, bit 2 is the debug reset, and bit 3 is the software request. Bits 4 and up hold the hardware request bits, with requester i at bit 4+i. The category input uses these encodings: 2'b00 means no reset triggered, 2'b01 means low-power entry, 2'b10 means software or peripheral request, and 2'b11 records nothing.

Top module: `rcause_top`

## Requirements
- R1: While `rstN` is low, and in the cycle after any edge where `porReq` was high, `regRdata` equals 1: only bit 0 is set.
- R2: After a power-on (`rstN` low or `porReq` high), no flag other than bit 0 is set until a clock edge samples `cpuRstN` high with `porReq` low.
- R3: When armed, with `cpuRstN` low and category 2'b01, bit 1 is set at the next edge.
- R4: When armed, with `cpuRstN` low and category 2'b10, bit 3 is set if `swReq` is high, and each high `hwReq[i]` sets bit 4+i.
- R5: `ndmReq` sets bit 2 only when armed, with `cpuRstN` low and category 2'b00. Under any other category it has no effect on bit 2.
- R6: No cause is recorded in a cycle where `cpuRstN` is high.
- R7: All causes permitted in the same cycle are recorded together. Flags already set are kept.
- R8: A write with `regWe` high clears exactly the bits written as 1 and leaves bits written as 0 unchanged.
- R9: If a write clears a bit in the same cycle that the bit is recorded, the bit ends up set.
- R10: A set flag stays set without a write, even after its cause goes away.
- R11: `porReq` takes priority over a simultaneous write and over any recording.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| porReq | input | 1 | Synchronous power-on indication, active high |
| cpuRstN | input | 1 | Processor reset state, low while the processor is in reset |
| ndmReq | input | 1 | Debug-module system reset request |
| pwrCat | input | 2 | Reset category from the power manager |
| swReq | input | 1 | Software reset request flag |
| hwReq | input | NumHw | Per-peripheral hardware reset requests |
| regWe | input | 1 | Write strobe for the write-1-to-clear access |
| regWdata | input | NumHw+4 | Write data, where a 1 clears that flag |
| regRdata | output | NumHw+4 | Current flags |

## Verification
Two things can land on the same flag in one cycle: a software clear and a new recording. The bench provokes this by writing all ones while the processor is held in reset under the low-power category. The check expects bit 1 to survive while every other bit is cleared. A power-on pulse is also driven together with a write and with active request inputs, and the result must hold only the power-on flag. In both cases a behavioural reference model is compared against the design on every clock.

// File: rtl/rcause_pkg.sv
package rcause_pkg;
  localparam int BitPor    = 0;
  localparam int BitLowPwr = 1;
  localparam int BitNdm    = 2;
  localparam int BitSw     = 3;
  localparam int HwLsb     = 4;

  typedef enum logic [1:0] {
    CatNone   = 2'b00,
    CatLowPwr = 2'b01,
    CatReq    = 2'b10,
    CatIdle   = 2'b11
  } cat_e;

  typedef struct packed {
    logic porLoad;
    logic recLowPwr;
    logic recNdm;
    logic recReq;
  } ctrl_strb_t;
endpackage

// File: rtl/rcause_ctrl.sv
module rcause_ctrl
  import rcause_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       porReq,
  input  logic       cpuRstN,
  input  logic       ndmReq,
  input  logic [1:0] pwrCat,
  output ctrl_strb_t strb
);
  logic muted;
  logic armedRec;
  cat_e cat;

  assign cat = cat_e'(pwrCat);

  // Muted from power-on until the processor reset is first seen released.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        muted <= 1'b1;
    else if (porReq)  muted <= 1'b1;
    else if (cpuRstN) muted <= 1'b0;
  end

  assign armedRec = !muted && !cpuRstN && !porReq;

  always_comb begin
    strb           = '0;
    strb.porLoad   = porReq;
    strb.recLowPwr = armedRec && (cat == CatLowPwr);
    strb.recReq    = armedRec && (cat == CatReq);
    strb.recNdm    = armedRec && (cat == CatNone) && ndmReq;
  end
endmodule

// File: rtl/rcause_dp.sv
module rcause_dp
  import rcause_pkg::*;
#(
  parameter int NumHw = 4,
  localparam int RegW = HwLsb + NumHw
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_strb_t       strb,
  input  logic             swReq,
  input  logic [NumHw-1:0] hwReq,
  input  logic             regWe,
  input  logic [RegW-1:0]  regWdata,
  output logic [RegW-1:0]  flags
);
  logic [RegW-1:0] clrMask;
  logic [RegW-1:0] setMask;

  assign clrMask = regWe ? regWdata : '0;

  always_comb begin
    setMask            = '0;
    setMask[BitLowPwr] = strb.recLowPwr;
    setMask[BitNdm]    = strb.recNdm;
    setMask[BitSw]     = strb.recReq && swReq;
  end

  // Power-on flag and the fixed cause flags.
  for (genvar b = 0; b < HwLsb; b++) begin : g_fixed
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             flags[b] <= (b == BitPor);
      else if (strb.porLoad) flags[b] <= (b == BitPor);
      else                   flags[b] <= (flags[b] && !clrMask[b]) || setMask[b];
    end
  end

  // One sticky flag per hardware requester.
  for (genvar i = 0; i < NumHw; i++) begin : g_hw
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             flags[HwLsb+i] <= 1'b0;
      else if (strb.porLoad) flags[HwLsb+i] <= 1'b0;
      else flags[HwLsb+i] <= (flags[HwLsb+i] && !clrMask[HwLsb+i])
                             || (strb.recReq && hwReq[i]);
    end
  end
endmodule

// File: rtl/rcause_top.sv
module rcause_top
  import rcause_pkg::*;
#(
  parameter int NumHw = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               porReq,
  input  logic               cpuRstN,
  input  logic               ndmReq,
  input  logic [1:0]         pwrCat,
  input  logic               swReq,
  input  logic [NumHw-1:0]   hwReq,
  input  logic               regWe,
  input  logic [NumHw+3:0]   regWdata,
  output logic [NumHw+3:0]   regRdata
);
  ctrl_strb_t strb;

  rcause_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .porReq  (porReq),
    .cpuRstN (cpuRstN),
    .ndmReq  (ndmReq),
    .pwrCat  (pwrCat),
    .strb    (strb)
  );

  rcause_dp #(.NumHw(NumHw)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .swReq    (swReq),
    .hwReq    (hwReq),
    .regWe    (regWe),
    .regWdata (regWdata),
    .flags    (regRdata)
  );
endmodule

// File: rtl/rcause_chk.sv
module rcause_chk #(
  parameter int NumHw = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             porReq,
  input logic             cpuRstN,
  input logic [1:0]       pwrCat,
  input logic             regWe,
  input logic [NumHw+3:0] regRdata
);
  logic seen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seen <= 1'b0;
    else       seen <= 1'b1;
  end

  // R1 R11: power-on leaves only the power-on flag.
  p_por_only_r11: assert property (@(posedge clk) disable iff (!rstN)
    porReq |=> (regRdata == {{(NumHw+3){1'b0}}, 1'b1}));

  // R2: still muted the cycle after power-on while the processor is in reset.
  p_muted_r2: assert property (@(posedge clk) disable iff (!rstN)
    (seen && $past(porReq) && !porReq && !cpuRstN && !regWe) |=> $stable(regRdata));

  // R5: debug reset flag untouched outside category none.
  p_ndm_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!porReq && !regWe && pwrCat != 2'b00) |=> $stable(regRdata[2]));

  // R10: flags only fall through a write or power-on.
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!porReq && !regWe) |=> ((regRdata & $past(regRdata)) == $past(regRdata)));

  // R3 R9: armed low-power recording sets bit 1 even under a clearing write.
  p_lowpwr_r9: assert property (@(posedge clk) disable iff (!rstN)
    (seen && $past(cpuRstN) && !$past(porReq) && !porReq && !cpuRstN
     && pwrCat == 2'b01) |=> regRdata[1]);
endmodule

bind rcause_top rcause_chk #(.NumHw(NumHw)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .porReq   (porReq),
  .cpuRstN  (cpuRstN),
  .pwrCat   (pwrCat),
  .regWe    (regWe),
  .regRdata (regRdata)
);

// File: tb/test_rcause_top.sv
module test_rcause_top;
  localparam int NumHw = 4;
  localparam int RegW  = NumHw + 4;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            porReq = 1'b0;
  logic            cpuRstN = 1'b0;
  logic            ndmReq = 1'b0;
  logic [1:0]      pwrCat = 2'b11;
  logic            swReq = 1'b0;
  logic [NumHw-1:0] hwReq = '0;
  logic            regWe = 1'b0;
  logic [RegW-1:0] regWdata = '0;
  logic [RegW-1:0] regRdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string curTag = "R1";

  logic [RegW-1:0] mFlags = 1;
  bit              mMuted = 1'b1;

  always #5 clk = ~clk;

  rcause_top #(.NumHw(NumHw)) i_rcause_top (
    .clk(clk), .rstN(rstN), .porReq(porReq), .cpuRstN(cpuRstN),
    .ndmReq(ndmReq), .pwrCat(pwrCat), .swReq(swReq), .hwReq(hwReq),
    .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata)
  );

  // Behavioural reference model.
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mFlags = 1;
      mMuted = 1'b1;
    end else if (porReq) begin
      mFlags = 1;
      mMuted = 1'b1;
    end else begin
      logic [RegW-1:0] nxt;
      nxt = mFlags;
      if (regWe) nxt = nxt & ~regWdata;
      if (!mMuted && !cpuRstN) begin
        case (pwrCat)
          2'b00: if (ndmReq) nxt[2] = 1'b1;
          2'b01: nxt[1] = 1'b1;
          2'b10: begin
            if (swReq) nxt[3] = 1'b1;
            for (int i = 0; i < NumHw; i++) if (hwReq[i]) nxt[4+i] = 1'b1;
          end
          default: ;
        endcase
      end
      if (cpuRstN) mMuted = 1'b0;
      mFlags = nxt;
    end
  end

  always @(negedge clk) begin
    cycles++;
    checks++;
    if (regRdata !== mFlags) begin
      errors++;
      $display("FAIL %s model compare: actual %b expected %b", curTag, regRdata, mFlags);
    end
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected at most 5000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic expect_val(input logic [RegW-1:0] exp, input string tag);
    checks++;
    if (regRdata !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, regRdata, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (2) step();
    expect_val(8'b0000_0001, "R1 in reset");
    rstN = 1'b1;
    curTag = "R2";
    pwrCat = 2'b01; cpuRstN = 1'b0;
    repeat (3) step();
    expect_val(8'b0000_0001, "R2 muted low power");
    pwrCat = 2'b00; ndmReq = 1'b1;
    step();
    expect_val(8'b0000_0001, "R2 muted ndm");
    ndmReq = 1'b0;

    curTag = "R6";
    cpuRstN = 1'b1; pwrCat = 2'b01;
    repeat (2) step();
    expect_val(8'b0000_0001, "R6 processor running");

    curTag = "R3";
    cpuRstN = 1'b0;
    step();
    expect_val(8'b0000_0011, "R3 low power");

    curTag = "R4";
    pwrCat = 2'b10; swReq = 1'b1; hwReq = 4'b0101;
    step();
    expect_val(8'b0101_1011, "R4 R7 sw and hw together");

    curTag = "R5";
    swReq = 1'b0; hwReq = '0; ndmReq = 1'b1;
    step();
    expect_val(8'b0101_1011, "R5 ndm under request category");
    pwrCat = 2'b11;
    step();
    expect_val(8'b0101_1011, "R5 ndm under idle category");
    pwrCat = 2'b00;
    step();
    expect_val(8'b0101_1111, "R5 ndm under none");
    ndmReq = 1'b0;

    curTag = "R10";
    cpuRstN = 1'b1; pwrCat = 2'b11;
    repeat (3) step();
    expect_val(8'b0101_1111, "R10 sticky");

    curTag = "R8";
    regWe = 1'b1; regWdata = 8'b0000_0010;
    step();
    regWe = 1'b0;
    expect_val(8'b0101_1101, "R8 clear bit1 only");
    regWe = 1'b1; regWdata = 8'b0001_0000;
    step();
    regWe = 1'b0;
    expect_val(8'b0100_1101, "R8 clear hw0 only");

    curTag = "R9";
    cpuRstN = 1'b0; pwrCat = 2'b01;
    regWe = 1'b1; regWdata = '1;
    step();
    regWe = 1'b0;
    expect_val(8'b0000_0010, "R9 record beats clear");

    curTag = "R11";
    porReq = 1'b1; regWe = 1'b1; regWdata = '1;
    pwrCat = 2'b10; swReq = 1'b1; hwReq = 4'b1111;
    step();
    porReq = 1'b0; regWe = 1'b0;
    expect_val(8'b0000_0001, "R11 power-on priority");

    curTag = "R2";
    step();
    expect_val(8'b0000_0001, "R2 muted after power-on pulse");
    cpuRstN = 1'b1; swReq = 1'b0; hwReq = 4'b1000;
    step();
    cpuRstN = 1'b0;
    step();
    expect_val(8'b1000_0001, "R2 R7 armed after release");

    step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule